// File: doc/BRIEF.md
# Shared Memory Port Arbiter

This block lets several compute modules that run at the same time share a single on-chip RAM port. Each requester drives a simple memory port: an address, an enable that is high when the port wants an access this cycle, a write-enable that picks write (1) or read (0), and write data. The arbiter picks one enabled requester per cycle in rotating order and passes its request straight through to the RAM in the same cycle. Every other enabled requester gets a stall signal, and while the stall is high the whole requesting module freezes.

The RAM is synchronous with one cycle of read latency. The arbiter keeps a registered copy of which requester won a read, so the word the RAM returns on the next cycle is sent only to that requester. All other read-data outputs stay at zero. A stalled requester must hold its request unchanged until it wins. Because the rotation moves past each winner, no requester waits more than `NUM_REQ-1` cycles in a row.

Per-requester fields are packed into flat vectors. Requester `i` occupies bits `[i*W +: W]`, where `W` is the width of that field.

Top module: `mem_share_arb`

## Requirements
- R1: After reset the rotation starts at requester 0 and no read is pending. In the first cycle after reset, with every requester enabled, requester 0 wins and every read-data output is zero.
- R2: When exactly one requester is enabled, it is granted in that same cycle and no stall is raised.
- R3: In any cycle with at least one enable high, exactly one enabled requester proceeds (stall low) and every other enabled requester has its stall high.
- R4: The search for a winner starts at the requester just after the most recent winner, wrapping from `NUM_REQ-1` to 0. As a result, an enabled requester is stalled for fewer than `NUM_REQ` cycles in a row.
- R5: In a cycle with no enable high, the RAM enable is low and the rotation position does not change.
- R6: The RAM enable is high exactly when a grant is made. The RAM address, write-enable and write data then equal the winner's fields, taken from its slice `[i*W +: W]`.
- R7: A read granted to requester `i` in cycle t puts the RAM output on requester `i`'s read data in cycle t+1. All other read-data slices are zero in that cycle.
- R8: In the cycle after an idle cycle or a granted write, every read-data slice is zero.
- R9: A requester whose enable is low never has its stall high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | NUM_REQ | Access request per requester |
| req_we | input | NUM_REQ | 1 = write, 0 = read, per requester |
| req_addr | input | NUM_REQ*ADDR_W | Packed word addresses |
| req_wdata | input | NUM_REQ*DATA_W | Packed write data |
| req_stall | output | NUM_REQ | Freeze request to each losing requester |
| req_rdata | output | NUM_REQ*DATA_W | Packed read data, valid one cycle after a granted read |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the read |

## Verification
The bench builds the block with `NUM_REQ=3`, `DEPTH=64` and `DATA_W=16`. Three requesters is not a power of two, so the wrap of the rotation from the last index back to 0 has to be done explicitly and is exercised on every cycle with contention. Random addresses are drawn from 16 words, which makes reads of freshly written data frequent. Directed phases cover full contention straight out of reset, idle gaps and a lone requester, and the random phase mixes reads, writes and held stalled requests.

// File: rtl/mem_share_arb_pkg.sv
package mem_share_arb_pkg;

    // Modular add for requester indices: a and b both below n.
    function automatic int wrap_add(input int a, input int b, input int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

    function automatic int wrap_inc(input int a, input int n);
        return wrap_add(a, 1, n);
    endfunction

endpackage

// File: rtl/mem_share_rr_pick.sv
// Rotating-priority picker: first enabled requester at or after ptr.
module mem_share_rr_pick #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [IDX_W-1:0]   ptr,
    output logic [NUM_REQ-1:0] gnt,
    output logic [IDX_W-1:0]   gidx,
    output logic               any
);
    import mem_share_arb_pkg::*;

    always_comb begin
        gnt  = '0;
        gidx = '0;
        // Walk offsets from farthest to nearest so the nearest wins last.
        for (int k = NUM_REQ - 1; k >= 0; k--) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                if (req[i] && (wrap_add(int'(ptr), k, NUM_REQ) == i)) begin
                    gnt    = '0;
                    gnt[i] = 1'b1;
                    gidx   = IDX_W'(i);
                end
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/mem_share_req_mux.sv
// Forwards the one-hot selected request fields to the RAM port.
module mem_share_req_mux #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic [NUM_REQ-1:0]        gnt,
    input  logic [NUM_REQ-1:0]        req_we,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic                      ram_en,
    output logic                      ram_we,
    output logic [ADDR_W-1:0]         ram_addr,
    output logic [DATA_W-1:0]         ram_wdata
);
    logic [ADDR_W-1:0] addr_m [NUM_REQ];
    logic [DATA_W-1:0] data_m [NUM_REQ];
    logic [NUM_REQ-1:0] we_m;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_mask
        assign addr_m[i] = gnt[i] ? req_addr[i*ADDR_W +: ADDR_W]  : '0;
        assign data_m[i] = gnt[i] ? req_wdata[i*DATA_W +: DATA_W] : '0;
        assign we_m[i]   = gnt[i] & req_we[i];
    end

    always_comb begin
        ram_addr  = '0;
        ram_wdata = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            ram_addr  = ram_addr  | addr_m[i];
            ram_wdata = ram_wdata | data_m[i];
        end
    end

    assign ram_we = |we_m;
    assign ram_en = |gnt;

endmodule

// File: rtl/mem_share_rdata_route.sv
// Steers RAM read data to the requester that won the previous read.
module mem_share_rdata_route #(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      rd_valid,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic [DATA_W-1:0]         ram_rdata,
    output logic [NUM_REQ*DATA_W-1:0] req_rdata
);
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_route
        assign req_rdata[i*DATA_W +: DATA_W] =
            (rd_valid && (rd_idx == IDX_W'(i))) ? ram_rdata : '0;
    end

endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb #(
    parameter int NUM_REQ = 4,
    parameter int DEPTH   = 256,
    parameter int DATA_W  = 32,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_en,
    input  logic [NUM_REQ-1:0]        req_we,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        req_stall,
    output logic [NUM_REQ*DATA_W-1:0] req_rdata,
    output logic                      ram_en,
    output logic                      ram_we,
    output logic [ADDR_W-1:0]         ram_addr,
    output logic [DATA_W-1:0]         ram_wdata,
    input  logic [DATA_W-1:0]         ram_rdata
);
    import mem_share_arb_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] rd_idx;
        logic             rd_valid;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic [NUM_REQ-1:0] gnt;
    logic [IDX_W-1:0]   gidx;
    logic               any_req;

    mem_share_rr_pick #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req  (req_en),
        .ptr  (st_q.ptr),
        .gnt  (gnt),
        .gidx (gidx),
        .any  (any_req)
    );

    mem_share_req_mux #(
        .NUM_REQ (NUM_REQ),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_mux (
        .gnt       (gnt),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    mem_share_rdata_route #(
        .NUM_REQ (NUM_REQ),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_route (
        .rd_valid  (st_q.rd_valid),
        .rd_idx    (st_q.rd_idx),
        .ram_rdata (ram_rdata),
        .req_rdata (req_rdata)
    );

    assign req_stall = req_en & ~gnt;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        if (any_req) begin
            st_d.ptr      = IDX_W'(wrap_inc(int'(gidx), NUM_REQ));
            st_d.rd_idx   = gidx;
            st_d.rd_valid = ~ram_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mem_share_arb_chk.sv
module mem_share_arb_chk #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_REQ-1:0]        req_en,
    input logic [NUM_REQ-1:0]        req_we,
    input logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input logic [NUM_REQ*DATA_W-1:0] req_wdata,
    input logic [NUM_REQ-1:0]        req_stall,
    input logic [NUM_REQ*DATA_W-1:0] req_rdata,
    input logic                      ram_en,
    input logic                      ram_we,
    input logic [ADDR_W-1:0]         ram_addr,
    input logic [DATA_W-1:0]         ram_wdata,
    input logic [DATA_W-1:0]         ram_rdata
);
    localparam int WCW = $clog2(NUM_REQ + 1) + 1;

    logic past_ok_q;
    logic [WCW-1:0] wait_q [NUM_REQ];

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_en) |-> ($countones(req_en & ~req_stall) == 1));

    assert_lone_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req_en) == 1) |-> (req_stall == '0));

    assert_idle_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_en) |-> !ram_en);

    assert_no_idle_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_stall & ~req_en) == '0));

    assert_quiet_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && !ram_we) |=> (req_rdata == '0));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (!rst_n)            wait_q[i] <= '0;
            else if (req_stall[i]) wait_q[i] <= wait_q[i] + 1'b1;
            else                   wait_q[i] <= '0;
        end

        assert_bounded_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_q[i] < WCW'(NUM_REQ)));

        // Contract on the requester side that R4 relies on.
        assert_hold_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok_q && $past(req_stall[i])) |->
                (req_en[i] && $stable(req_we[i])
                 && $stable(req_addr[i*ADDR_W +: ADDR_W])
                 && $stable(req_wdata[i*DATA_W +: DATA_W])));

        assert_forward_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_en[i] && !req_stall[i]) |->
                (ram_en && (ram_we == req_we[i])
                 && (ram_addr == req_addr[i*ADDR_W +: ADDR_W])
                 && (ram_wdata == req_wdata[i*DATA_W +: DATA_W])));

        assert_read_to_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ram_en && !ram_we && req_en[i] && !req_stall[i]) |=>
                (req_rdata[i*DATA_W +: DATA_W] == ram_rdata));

        assert_read_not_loser_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ram_en && !ram_we && !(req_en[i] && !req_stall[i])) |=>
                (req_rdata[i*DATA_W +: DATA_W] == '0));
    end

endmodule

bind mem_share_arb mem_share_arb_chk #(
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_en    (req_en),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_stall (req_stall),
    .req_rdata (req_rdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata)
);

// File: tb/sim_mem_share_arb.sv
`timescale 1ns/1ps
module sim_mem_share_arb;
    localparam int N  = 3;
    localparam int DP = 64;
    localparam int DW = 16;
    localparam int AW = $clog2(DP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_en = '0;
    logic [N-1:0]    req_we = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    req_stall;
    logic [N*DW-1:0] req_rdata;
    logic            ram_en, ram_we;
    logic [AW-1:0]   ram_addr;
    logic [DW-1:0]   ram_wdata;
    logic [DW-1:0]   ram_rdata;

    always #4 clk = ~clk;

    mem_share_arb #(.NUM_REQ(N), .DEPTH(DP), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stall(req_stall),
        .req_rdata(req_rdata), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model: synchronous, one cycle read latency.
    logic [DW-1:0] ram_mem [DP];
    logic [DW-1:0] ram_q = '0;
    assign ram_rdata = ram_q;
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram_mem[ram_addr] <= ram_wdata;
            else        ram_q <= ram_mem[ram_addr];
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N-1:0]  p_en, p_we;
    logic [AW-1:0] p_addr [N];
    logic [DW-1:0] p_wd   [N];
    logic [DW-1:0] exp_mem [DP];
    int            exp_ptr;
    bit            exp_rv;
    int            exp_ri;
    logic [DW-1:0] exp_rd;
    bit            first_cycle;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick(input logic [N-1:0] en, input int ptr);
        for (int k = 0; k < N; k++) begin
            if (en[(ptr + k) % N]) return (ptr + k) % N;
        end
        return -1;
    endfunction

    task automatic new_req(input int i);
        p_en[i]   = ($urandom % 100) < 55;
        p_we[i]   = $urandom % 2;
        p_addr[i] = AW'($urandom % 16);
        p_wd[i]   = DW'($urandom);
    endtask

    task automatic run_cycle(input bit refill);
        int g;
        logic [N-1:0] exp_stall;
        req_en = p_en;
        req_we = p_we;
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW]  = p_addr[i];
            req_wdata[i*DW +: DW] = p_wd[i];
        end
        #2;
        g = pick(p_en, exp_ptr);
        exp_stall = p_en;
        if (g >= 0) exp_stall[g] = 1'b0;
        if (first_cycle)
            chk("R1", "stall after reset", 64'(req_stall), 64'(exp_stall));
        else if ($countones(p_en) == 1)
            chk("R2", "lone stall", 64'(req_stall), 64'(exp_stall));
        else
            chk("R3/R4", "stall vector", 64'(req_stall), 64'(exp_stall));
        chk("R9", "stall of idle requesters", 64'(req_stall & ~p_en), 64'd0);
        chk(g < 0 ? "R5" : "R6", "ram_en", 64'(ram_en), 64'(g >= 0));
        if (g >= 0) begin
            chk("R6", "ram_addr",  64'(ram_addr),  64'(p_addr[g]));
            chk("R6", "ram_we",    64'(ram_we),    64'(p_we[g]));
            chk("R6", "ram_wdata", 64'(ram_wdata), 64'(p_wd[g]));
        end
        for (int i = 0; i < N; i++) begin
            logic [DW-1:0] e;
            e = (exp_rv && exp_ri == i) ? exp_rd : '0;
            chk(first_cycle ? "R1" : (exp_rv ? "R7" : "R8"), "rdata",
                64'(req_rdata[i*DW +: DW]), 64'(e));
        end
        first_cycle = 0;
        // Model update for the coming edge.
        if (g >= 0) begin
            exp_ptr = (g + 1) % N;
            exp_rv  = !p_we[g];
            exp_ri  = g;
            exp_rd  = exp_mem[p_addr[g]];
            if (p_we[g]) exp_mem[p_addr[g]] = p_wd[g];
            p_en[g] = 1'b0;
        end else begin
            exp_rv = 0;
        end
        if (refill) begin
            for (int i = 0; i < N; i++) if (!p_en[i]) new_req(i);
        end
        @(negedge clk);
    endtask

    initial begin
        int limit;
        limit = 100000;
        repeat (limit) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < DP; a++) begin
            ram_mem[a] = '0;
            exp_mem[a] = '0;
        end
        p_en = '0; p_we = '0;
        for (int i = 0; i < N; i++) begin p_addr[i] = '0; p_wd[i] = '0; end
        exp_ptr = 0; exp_rv = 0; exp_ri = 0; exp_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        first_cycle = 1;

        // R1/R4: every requester writes at once; grants rotate 0,1,2.
        for (int i = 0; i < N; i++) begin
            p_en[i] = 1'b1; p_we[i] = 1'b1;
            p_addr[i] = AW'(i + 4); p_wd[i] = DW'(16'hA000 + i);
        end
        repeat (N) run_cycle(0);
        // R7: every requester reads its own word back, in rotation.
        for (int i = 0; i < N; i++) begin
            p_en[i] = 1'b1; p_we[i] = 1'b0; p_addr[i] = AW'(i + 4);
        end
        repeat (N) run_cycle(0);
        // R5/R8: idle gap keeps the rotation where it was.
        repeat (2) run_cycle(0);
        // R2: lone requester 2, then lone requester 0.
        p_en[2] = 1'b1; p_we[2] = 1'b0; p_addr[2] = AW'(5);
        run_cycle(0);
        run_cycle(0);
        p_en[0] = 1'b1; p_we[0] = 1'b1; p_addr[0] = AW'(9); p_wd[0] = 16'h5A5A;
        run_cycle(0);
        run_cycle(0);

        // Random mix with stalled requests held.
        for (int i = 0; i < N; i++) new_req(i);
        repeat (1500) run_cycle(1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule